// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the purely combinational arithmetic and logic stage of a 32-bit integer datapath. It receives the first operand from the register file and the second operand from the barrel shifter, together with the shifter's carry-out. It also receives the current negative, zero, carry and overflow flags and a 4-bit operation code. From these it produces the operation result, a write strobe for the destination register and the next value of the four flags.

Compare and test operations always update the flags and never write the destination. The other operations update the flags only when the set-flags input is high. If the flags would be updated, the destination is the program counter and the current mode owns a saved status word, the block computes no flags at all. Instead it raises a separate restore-status select, so that the surrounding core can copy the saved status back into the live one. Register-file access and program-counter handling stay outside the block.

Top module: `dp_alu`

## Requirements
- R1: The logical operations give these results: code 0 gives A AND B, 1 gives A XOR B, 12 gives A OR B, 13 gives B, 14 gives A AND NOT B, and 15 gives NOT B.
- R2: The plain arithmetic operations give these results: code 4 (add) gives A+B, 2 (subtract) gives A−B, and 3 (reverse subtract) gives B−A, all modulo 2^32.
- R3: The carry-using operations take the incoming carry flag (flags_in bit 1) as C. Code 5 gives A+B+C, 6 gives A−B−(1−C), and 7 gives B−A−(1−C).
- R4: For arithmetic operations the C flag (bit 1) works as follows. For additions it is the carry out of the full 33-bit sum, including the carry-in. For subtractions it is NOT borrow, so it is 1 when the minuend is at least the subtrahend plus any borrow-in. Reverse forms use B as the minuend.
- R5: For arithmetic operations the V flag (bit 0) is 1 exactly when the true signed result does not fit in 32 bits.
- R6: When flags are computed, N (bit 3) equals result bit 31 and Z (bit 2) is 1 exactly when the result is zero.
- R7: For logical operations, and for code 8 (test AND) and code 9 (test XOR), C comes from shift_carry and V keeps its incoming value.
- R8: Codes 8 to 11 (test AND, test XOR, compare as subtract, compare as add) hold dest_we low. They update the flags even when set_flags is low.
- R9: Codes 0–7 and 12–15 hold dest_we high. With set_flags low they pass flags_in through unchanged.
- R10: When flags would be updated, dest_is_pc is high and mode_has_saved is high, restore_status is high and flags_out equals flags_in. In every other case restore_status is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand (register value) |
| op_b | input | 32 | Second operand (shifter output) |
| shift_carry | input | 1 | Carry-out of the shifter |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| opcode | input | 4 | Operation code 0..15 |
| set_flags | input | 1 | Request a flag update |
| dest_is_pc | input | 1 | Destination is the program counter |
| mode_has_saved | input | 1 | Current mode owns a saved status word |
| result | output | 32 | Operation result |
| dest_we | output | 1 | Destination write strobe |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| restore_status | output | 1 | Select saved status instead of computed flags |

## Verification
Immediate assertions re-evaluate whenever the inputs settle. They check the structural flag rules: compare and test codes never write, flags pass through when no update is requested or a restore is selected, N and Z track the result, and logical codes keep V. The arithmetic correctness is left to the bench's directed scenarios, because it cannot be stated without a second adder. This covers the results, the carry as not-borrow, the use of the incoming carry in the carry forms and signed overflow at the 0x7FFFFFFF/0x80000000 boundaries. These scenarios compare against a 64-bit reference model.

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             shift_carry,
  input  logic [3:0]       flags_in,
  input  logic [3:0]       opcode,
  input  logic             set_flags,
  input  logic             dest_is_pc,
  input  logic             mode_has_saved,
  output logic [WIDTH-1:0] result,
  output logic             dest_we,
  output logic [3:0]       flags_out,
  output logic             restore_status
);
  localparam int MSB = WIDTH - 1;

  logic             is_cmp, is_arith, upd;
  logic [WIDTH-1:0] ax, ay;
  logic             cin;
  logic [WIDTH:0]   sum;
  logic [WIDTH-1:0] logic_res;
  logic             v_arith;

  assign is_cmp   = opcode[3:2] == 2'b10;
  assign is_arith = (opcode[3:2] == 2'b01) || (opcode[3:1] == 3'b001) || (opcode[3:1] == 3'b101);
  assign upd      = set_flags | is_cmp;
  assign dest_we  = ~is_cmp;
  assign restore_status = upd & dest_is_pc & mode_has_saved;

  always_comb begin
    ax  = op_a;
    ay  = op_b;
    cin = 1'b0;
    case (opcode)
      4'h2, 4'hA: begin ay = ~op_b; cin = 1'b1; end
      4'h3:       begin ax = op_b; ay = ~op_a; cin = 1'b1; end
      4'h5:       cin = flags_in[1];
      4'h6:       begin ay = ~op_b; cin = flags_in[1]; end
      4'h7:       begin ax = op_b; ay = ~op_a; cin = flags_in[1]; end
      default:    ;
    endcase
  end

  assign sum     = {1'b0, ax} + {1'b0, ay} + {{WIDTH{1'b0}}, cin};
  assign v_arith = (ax[MSB] == ay[MSB]) && (sum[MSB] != ax[MSB]);

  always_comb begin
    case (opcode)
      4'h0, 4'h8: logic_res = op_a & op_b;
      4'h1, 4'h9: logic_res = op_a ^ op_b;
      4'hC:       logic_res = op_a | op_b;
      4'hD:       logic_res = op_b;
      4'hE:       logic_res = op_a & ~op_b;
      default:    logic_res = ~op_b;
    endcase
  end

  assign result = is_arith ? sum[MSB:0] : logic_res;

  always_comb begin
    flags_out = flags_in;
    if (upd && !restore_status) begin
      flags_out[3] = result[MSB];
      flags_out[2] = ~|result;
      if (is_arith) begin
        flags_out[1] = sum[WIDTH];
        flags_out[0] = v_arith;
      end else begin
        flags_out[1] = shift_carry;
      end
    end
  end

  always_comb begin
    a_r8_cmp_no_write: assert (!(opcode[3:2] == 2'b10) || !dest_we);
    a_r9_flags_hold: assert (set_flags || (opcode[3:2] == 2'b10) || flags_out == flags_in);
    a_r10_restore_keeps: assert (!restore_status || flags_out == flags_in);
    a_r6_nz_track: assert (!(set_flags && !dest_is_pc) ||
                           (flags_out[3] == result[MSB] && flags_out[2] == (result == '0)));
    a_r7_v_kept: assert (is_arith || flags_out[0] == flags_in[0]);
  end
endmodule

// File: tb/sim_dp_alu.sv
module sim_dp_alu;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] a, b, res;
  logic        sc, sf, pc, ms, we, rst_o;
  logic [3:0]  fi, op, fo;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  dp_alu u0 (
    .op_a(a), .op_b(b), .shift_carry(sc), .flags_in(fi), .opcode(op),
    .set_flags(sf), .dest_is_pc(pc), .mode_has_saved(ms),
    .result(res), .dest_we(we), .flags_out(fo), .restore_status(rst_o)
  );

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'h2, 4'h3, 4'h4: return "R2";
      4'h5, 4'h6, 4'h7: return "R3";
      4'h8, 4'h9, 4'hA, 4'hB: return "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic apply_and_check(input logic [3:0] o, input logic [31:0] va, input logic [31:0] vb,
                                 input logic s, input logic [3:0] f, input logic setf,
                                 input logic topc, input logic msaved);
    longint unsigned ua, ub, cc, full;
    longint sa, sb, sr;
    logic [31:0] er;
    logic [3:0]  ef;
    logic        arith, cmpop, upd, rs, ec, ev;
    a = va; b = vb; sc = s; fi = f; op = o; sf = setf; pc = topc; ms = msaved;
    @(negedge clk);
    ua = longint'(va); ub = longint'(vb); cc = longint'(f[1]);
    sa = longint'($signed(va)); sb = longint'($signed(vb));
    arith = 1'b1; ec = 1'b0; sr = 0;
    er = '0;
    case (o)
      4'h4, 4'hB: begin full = ua + ub;      er = full[31:0]; ec = full[32]; sr = sa + sb; end
      4'h5:       begin full = ua + ub + cc; er = full[31:0]; ec = full[32]; sr = sa + sb + longint'(cc); end
      4'h2, 4'hA: begin er = va - vb; ec = ua >= ub; sr = sa - sb; end
      4'h3:       begin er = vb - va; ec = ub >= ua; sr = sb - sa; end
      4'h6:       begin er = va - vb - {31'b0, ~f[1]}; ec = ua >= ub + (1 - cc); sr = sa - sb - longint'(1 - cc); end
      4'h7:       begin er = vb - va - {31'b0, ~f[1]}; ec = ub >= ua + (1 - cc); sr = sb - sa - longint'(1 - cc); end
      default: begin
        arith = 1'b0;
        case (o)
          4'h0, 4'h8: er = va & vb;
          4'h1, 4'h9: er = va ^ vb;
          4'hC: er = va | vb;
          4'hD: er = vb;
          4'hE: er = va & ~vb;
          default: er = ~vb;
        endcase
      end
    endcase
    ev = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    cmpop = (o >= 4'h8) && (o <= 4'hB);
    upd = setf | cmpop;
    rs = upd & topc & msaved;
    ef = f;
    if (upd && !rs) begin
      ef[3] = er[31];
      ef[2] = (er == 32'h0);
      ef[1] = arith ? ec : s;
      ef[0] = arith ? ev : f[0];
    end
    if (!cmpop) chk(req_of(o), "result", res, er);
    chk(cmpop ? "R8" : "R9", "dest_we", {31'b0, we}, {31'b0, ~cmpop});
    chk(rs ? "R10" : (arith ? "R4/R5/R6" : "R6/R7"), "flags", {28'b0, fo}, {28'b0, ef});
    chk("R10", "restore", {31'b0, rst_o}, {31'b0, rs});
  endtask

  task automatic t_idle;
    apply_and_check(4'h0, 32'h0, 32'h0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_logic_r1_r7;
    for (int o = 0; o < 16; o++)
      if (o < 2 || o > 11)
        apply_and_check(o[3:0], 32'hF0F0_1234, 32'h0FF0_8765, 1'b1, 4'b0001, 1'b1, 1'b0, 1'b0);
    apply_and_check(4'hD, 32'h0, 32'h0, 1'b0, 4'b1011, 1'b1, 1'b0, 1'b0);
    apply_and_check(4'hF, 32'h0, 32'h0, 1'b1, 4'b0000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_add_sub_r2_r4_r5;
    apply_and_check(4'h4, 32'h7FFF_FFFF, 32'h1, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0);
    apply_and_check(4'h4, 32'hFFFF_FFFF, 32'h1, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0);
    apply_and_check(4'h4, 32'h8000_0000, 32'h8000_0000, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0);
    apply_and_check(4'h2, 32'h5, 32'h5, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0);
    apply_and_check(4'h2, 32'h3, 32'h5, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0);
    apply_and_check(4'h2, 32'h8000_0000, 32'h1, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0);
    apply_and_check(4'h3, 32'h3, 32'h5, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0);
    apply_and_check(4'h3, 32'h1, 32'h8000_0000, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_carry_forms_r3;
    for (int c = 0; c < 2; c++) begin
      apply_and_check(4'h5, 32'hFFFF_FFFF, 32'h0, 1'b0, {2'b00, c[0], 1'b0}, 1'b1, 1'b0, 1'b0);
      apply_and_check(4'h5, 32'h7FFF_FFFF, 32'h0, 1'b0, {2'b00, c[0], 1'b0}, 1'b1, 1'b0, 1'b0);
      apply_and_check(4'h6, 32'h5, 32'h5, 1'b0, {2'b00, c[0], 1'b0}, 1'b1, 1'b0, 1'b0);
      apply_and_check(4'h6, 32'h8000_0000, 32'h0, 1'b0, {2'b00, c[0], 1'b0}, 1'b1, 1'b0, 1'b0);
      apply_and_check(4'h7, 32'h5, 32'h5, 1'b0, {2'b00, c[0], 1'b0}, 1'b1, 1'b0, 1'b0);
      apply_and_check(4'h7, 32'h0, 32'h9, 1'b0, {2'b00, c[0], 1'b0}, 1'b1, 1'b0, 1'b0);
    end
  endtask

  task automatic t_compare_r8;
    apply_and_check(4'h8, 32'hFF00, 32'h00FF, 1'b1, 4'b0001, 1'b0, 1'b0, 1'b0);
    apply_and_check(4'h9, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b0, 4'b0100, 1'b0, 1'b0, 1'b0);
    apply_and_check(4'hA, 32'h10, 32'h20, 1'b1, 4'b0110, 1'b0, 1'b0, 1'b0);
    apply_and_check(4'hB, 32'hFFFF_FFFF, 32'h1, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_noflags_r9;
    for (int o = 0; o < 16; o++)
      if (o < 8 || o > 11)
        apply_and_check(o[3:0], 32'h8000_0000, 32'h8000_0000, 1'b1, 4'b1010, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_restore_r10;
    apply_and_check(4'h2, 32'h1, 32'h2, 1'b0, 4'b0101, 1'b1, 1'b1, 1'b1);
    apply_and_check(4'hA, 32'h1, 32'h2, 1'b0, 4'b0101, 1'b0, 1'b1, 1'b1);
    apply_and_check(4'h2, 32'h1, 32'h2, 1'b0, 4'b0101, 1'b1, 1'b1, 1'b0);
    apply_and_check(4'hD, 32'h0, 32'h0, 1'b1, 4'b0000, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_sweep;
    logic [31:0] pa [4] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5678};
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          apply_and_check(o[3:0], pa[i], pa[j], j[0], {i[0], j[1], i[1], j[0]}, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    for (int n = 0; n < 100000; n++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    a = '0; b = '0; sc = 0; fi = '0; op = '0; sf = 0; pc = 0; ms = 0;
    repeat (2) @(negedge clk);
    t_idle();
    t_logic_r1_r7();
    t_add_sub_r2_r4_r5();
    t_carry_forms_r3();
    t_compare_r8();
    t_noflags_r9();
    t_restore_r10();
    t_sweep();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule